// File: doc/BRIEF.md
# Calendar Request Issuer with Backoff

This block sits on the client side of a channelized request pipeline. It walks a small programmable calendar of channel entries, each holding a channel number and an idle-count adjustment. For each calendar occurrence it emits one request that carries both values. A credit accumulator sets the pace, so that `rate_num` requests leave for every `rate_den` clock cycles. In the cycles between slots the request strobe stays low.

The downstream pipeline returns one level signal, `req_ready`. Nothing leaves the block until `req_ready` has been sampled high once after reset. Later, whenever `req_ready` is sampled low, the block applies back-pressure to itself. It skips every second credit-earned slot, which at least halves its request rate. It returns to the full programmed rate in the first cycle in which `req_ready` is sampled high again.

Back-pressure rules at the request interface: every cycle with `req_valid` high is one accepted request, and there is no per-beat handshake. `req_ready` only sets the pace, and a request is never held waiting for it. Software fills the calendar through a one-entry-per-cycle write port, which it may use at any time. The length is set by `cal_len`.

Top module: `cal_req_issuer`

## Requirements
- R1: `req_valid` stays low from reset until `req_ready` has been sampled high at a rising edge. The request earliest possible appears after the following edge, when the programmed rate allows one slot per cycle.
- R2: Each request drives the 6-bit `req_chan` and the 6-bit `req_sic` of the same calendar entry in the same cycle as `req_valid`. A SIC of 0 and a SIC of 63 are carried unchanged.
- R3: Entries are issued in address order from 0 to `cal_len`-1, and the pointer then wraps to 0. A `cal_len` of 0 or 1 repeats entry 0.
- R4: When `rate_num` >= `rate_den` (this includes `rate_den` = 0) and `req_ready` is high, a request is issued in every cycle.
- R5: Otherwise, in steady state with `req_ready` high, exactly `rate_num` requests are issued in every `rate_den` consecutive cycles.
- R6: While `req_ready` is sampled low, credit-earned slots alternate between issue and skip, and the first one after the drop issues. The rate is therefore at most half the programmed rate.
- R7: Once `req_ready` is sampled high again, every credit-earned slot issues, which restores the programmed rate.
- R8: A calendar write takes effect the first time the pointer reaches that entry after the write edge. If a write hits the entry that is being issued at that same edge, that request still carries the old contents.
- R9: During reset `req_valid`, `req_chan` and `req_sic` are 0, and the pointer restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | input | 1 | Pipeline level: high = take requests at full rate |
| rate_num | input | 8 | Request slots per window |
| rate_den | input | 8 | Window length in cycles |
| cal_len | input | 7 | Number of active calendar entries |
| cal_we | input | 1 | Calendar write strobe |
| cal_waddr | input | 6 | Calendar entry to write |
| cal_wchan | input | 6 | Channel number to store |
| cal_wsic | input | 6 | SIC adjustment to store |
| req_valid | output | 1 | One request this cycle |
| req_chan | output | 6 | Requested channel |
| req_sic | output | 6 | SIC adjustment for that channel |

## Verification
Two functions can land on the same clock edge: a calendar write and the issue of the very entry being written. The bench sets a rate of one slot in eight, so it can predict the issue edge. It waits for a request and then drives the write so that it spans exactly the next issue edge. A second write goes to the following entry one edge later. The judgement is that the colliding request still carries the old values. The next entry and the next pass over the written entry must both show the new ones. A scoreboard with a snapshot of the calendar taken before each edge checks every other request in the run.

// File: rtl/cal_req_pkg.sv
package cal_req_pkg;
  localparam int CHAN_W = 6;
  localparam int SIC_W  = 6;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [SIC_W-1:0]  sic;
  } cal_entry_t;
endpackage

// File: rtl/cal_table.sv
module cal_table
  import cal_req_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        wr_en,
  input  logic [AW-1:0] wr_addr,
  input  cal_entry_t  wr_data,
  input  logic [AW-1:0] rd_addr,
  output cal_entry_t  rd_data
);
  cal_entry_t mem [DEPTH];

  // Write lands at the edge; a read in the same cycle still sees old data.
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cal_pointer.sv
module cal_pointer #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q;
  logic          at_last;

  assign at_last = (LW'(ptr_q) + LW'(1)) >= len;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= at_last ? '0 : ptr_q + AW'(1);
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rate_credit.sv
module rate_credit #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] num,
  input  logic [RATE_W-1:0] den,
  output logic              elig
);
  logic [RATE_W-1:0] acc_q, acc_eff, acc_d;
  logic [RATE_W:0]   sum;
  logic              full, hit;

  assign full    = (num >= den);
  assign acc_eff = (acc_q >= den) ? '0 : acc_q;
  assign sum     = {1'b0, acc_eff} + {1'b0, num};
  assign hit     = full || (sum >= {1'b0, den});
  assign elig    = run && hit;

  always_comb begin
    acc_d = acc_q;
    if (run) begin
      if (full)     acc_d = '0;
      else if (hit) acc_d = RATE_W'(sum - {1'b0, den});
      else          acc_d = sum[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R5: with a steady window, leftover credit stays below one window
  p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run && (num < den)) && $stable(den)) |-> (acc_q < den));
endmodule

// File: rtl/backoff_gate.sv
module backoff_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic elig,
  output logic started,
  output logic issue
);
  logic started_q, skip_q;

  assign issue = started_q && elig && (ready || !skip_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      skip_q    <= 1'b0;
    end else begin
      started_q <= started_q || ready;
      if (!started_q || ready) skip_q <= 1'b0;
      else if (elig)           skip_q <= !skip_q;
    end
  end

  assign started = started_q;
endmodule

// File: rtl/cal_req_issuer.sv
module cal_req_issuer
  import cal_req_pkg::*;
#(
  parameter  int DEPTH  = 64,
  parameter  int RATE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_ready,
  input  logic [RATE_W-1:0] rate_num,
  input  logic [RATE_W-1:0] rate_den,
  input  logic [LW-1:0]     cal_len,
  input  logic              cal_we,
  input  logic [AW-1:0]     cal_waddr,
  input  logic [CHAN_W-1:0] cal_wchan,
  input  logic [SIC_W-1:0]  cal_wsic,
  output logic              req_valid,
  output logic [CHAN_W-1:0] req_chan,
  output logic [SIC_W-1:0]  req_sic
);
  logic          started, elig, issue;
  logic [AW-1:0] ptr;
  cal_entry_t    wr_ent, rd_ent;
  logic          valid_q, bo_q;
  cal_entry_t    out_q;

  assign wr_ent = '{chan: cal_wchan, sic: cal_wsic};

  cal_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .wr_en(cal_we), .wr_addr(cal_waddr), .wr_data(wr_ent),
    .rd_addr(ptr), .rd_data(rd_ent)
  );

  cal_pointer #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(issue), .len(cal_len), .ptr(ptr)
  );

  rate_credit #(.RATE_W(RATE_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .run(started),
    .num(rate_num), .den(rate_den), .elig(elig)
  );

  backoff_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ready(req_ready), .elig(elig),
    .started(started), .issue(issue)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
      bo_q    <= 1'b0;
    end else begin
      valid_q <= issue;
      bo_q    <= !req_ready;
      if (issue) out_q <= rd_ent;
    end
  end

  assign req_valid = valid_q;
  assign req_chan  = out_q.chan;
  assign req_sic   = out_q.sic;

  // R1: nothing leaves before ready was seen
  p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !req_valid);

  // R4: full programmed rate with ready high gives a request every cycle
  p_full_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && req_ready && (rate_num >= rate_den)) |=> req_valid);

  // R6: two requests issued under backoff are never adjacent
  p_backoff_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bo_q) |=> !(req_valid && bo_q));
endmodule

// File: tb/cal_req_issuer_tb.sv
`timescale 1ns/1ps
module cal_req_issuer_tb;
  import cal_req_pkg::*;
  localparam int DEPTH = 64;

  logic       clk = 1'b0, rst_n = 1'b0, req_ready = 1'b0;
  logic [7:0] rate_num = 8'd1, rate_den = 8'd1;
  logic [6:0] cal_len = 7'd5;
  logic       cal_we = 1'b0;
  logic [5:0] cal_waddr = '0, cal_wchan = '0, cal_wsic = '0;
  logic       req_valid;
  logic [5:0] req_chan, req_sic;

  always #4 clk = ~clk;

  cal_req_issuer u_dut (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .rate_num(rate_num), .rate_den(rate_den), .cal_len(cal_len),
    .cal_we(cal_we), .cal_waddr(cal_waddr), .cal_wchan(cal_wchan),
    .cal_wsic(cal_wsic), .req_valid(req_valid), .req_chan(req_chan),
    .req_sic(req_sic)
  );

  int checks = 0, errors = 0, n_obs = 0, cyc = 0, exp_ptr = 0;
  cal_entry_t exp_cal [DEPTH];
  cal_entry_t snap [DEPTH];
  cal_entry_t exp_q [$];
  cal_entry_t last_obs;

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model calendar: snapshot holds contents as they stood before each edge
  always @(posedge clk) begin
    snap <= exp_cal;
    if (cal_we) exp_cal[cal_waddr] <= cal_entry_t'{cal_wchan, cal_wsic};
  end

  task automatic push_expected();
    exp_q.push_back(snap[exp_ptr]);
    exp_ptr = (exp_ptr + 1 >= int'(cal_len)) ? 0 : exp_ptr + 1;
  endtask

  always @(negedge clk) begin
    cal_entry_t e;
    if (rst_n && req_valid) begin
      push_expected();
      e = exp_q.pop_front();
      check(req_chan == e.chan, "R3", req_chan, e.chan, "channel order");
      check(req_sic == e.sic, "R2", req_sic, e.sic, "sic value");
      last_obs = cal_entry_t'{req_chan, req_sic};
      n_obs++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 30000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 30000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // caller stands at a negedge; write spans exactly the next rising edge
  task automatic cal_write(int a, int c, int s);
    cal_we = 1'b1; cal_waddr = 6'(a); cal_wchan = 6'(c); cal_wsic = 6'(s);
    @(negedge clk);
    cal_we = 1'b0;
  endtask

  task automatic window(int k, output int n);
    int s;
    #1 s = n_obs;
    repeat (k) @(negedge clk);
    #1 n = n_obs - s;
  endtask

  task automatic set_rate(int n, int d);
    @(negedge clk);
    rate_num = 8'(n); rate_den = 8'(d);
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_obs();
    int s;
    s = n_obs;
    do begin @(negedge clk); #1; end while (n_obs == s);
  endtask

  initial begin
    int n, a, a1;
    cal_entry_t old;
    repeat (3) @(negedge clk);
    check(req_valid == 0, "R9", req_valid, 0, "valid in reset");
    check(req_chan == 0 && req_sic == 0, "R9", {req_chan, req_sic}, 0, "data in reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++)
      cal_write(i, (i * 13 + 5) % 64, (i == 4) ? 0 : 63 - i * 10);
    window(20, n);
    check(n == 0, "R1", n, 0, "requests before ready seen");
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk);
    check(req_valid == 0, "R1", req_valid, 0, "valid at ready sample edge");
    @(negedge clk);
    check(req_valid == 1, "R1", req_valid, 1, "first request");
    window(40, n);
    check(n == 40, "R4", n, 40, "full rate count");
    set_rate(1, 3); window(60, n);
    check(n == 20, "R5", n, 20, "rate 1/3 count");
    set_rate(2, 5); window(60, n);
    check(n == 24, "R5", n, 24, "rate 2/5 count");
    set_rate(1, 1);
    @(negedge clk); req_ready = 1'b0;
    repeat (6) @(negedge clk);
    window(40, n);
    check(n == 20, "R6", n, 20, "backoff at full rate");
    set_rate(1, 3); window(60, n);
    check(n == 10, "R6", n, 10, "backoff at rate 1/3");
    @(negedge clk); req_ready = 1'b1;
    repeat (6) @(negedge clk);
    window(60, n);
    check(n == 20, "R7", n, 20, "resume at rate 1/3");
    set_rate(1, 1); window(40, n);
    check(n == 40, "R7", n, 40, "resume at full rate");
    set_rate(0, 0); window(20, n);
    check(n == 20, "R4", n, 20, "zero window means full rate");
    // R8 collision: one slot in eight makes the issue edge predictable
    set_rate(1, 8);
    repeat (20) @(negedge clk);
    wait_obs();
    a = exp_ptr; a1 = (a + 1) % 5;
    old = exp_cal[a];
    repeat (7) @(posedge clk);
    @(negedge clk);
    cal_write(a, 50, 21);
    cal_write(a1, 44, 7);
    check(last_obs == old, "R8", last_obs, old, "request at write edge keeps old entry");
    wait_obs();
    check(last_obs == cal_entry_t'{6'd44, 6'd7}, "R8", last_obs, {6'd44, 6'd7}, "entry ahead updated");
    repeat (4) wait_obs();
    check(last_obs == cal_entry_t'{6'd50, 6'd21}, "R8", last_obs, {6'd50, 6'd21}, "written entry next pass");
    set_rate(1, 1);
    @(negedge clk); cal_len = 7'd1;
    repeat (8) @(negedge clk);
    wait_obs();
    check(last_obs == exp_cal[0], "R3", last_obs, exp_cal[0], "length one repeats entry 0");
    check(n_obs > 100, "R3", n_obs, 101, "scoreboard item volume");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule